// File: doc/BRIEF.md
# Dual-Compare Timer/Counter

A 16-bit timer/counter for waveform generation, periodic interrupts and event counting. Software programs it through four word-wide registers on a simple register bus: a control word, the live count, and two compare limits (first and second). Each enabled tick advances the count. When the count equals the active limit, the next tick returns it to zero and an interrupt pulse may be raised.

In single-limit mode only the first compare is used, and the waveform pin toggles on every wrap. In two-limit mode the timer alternates between the first and second limits. The pin is high while the first limit is active and low while the second is active, so the duty cycle is set by the ratio of the two limits. The timer either runs continuously or stops by itself after one full pass. The count source is the internal clock, a synchronized external event pin (rising edges), or a one-cycle tick from a companion prescaler timer.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset every register reads zero, `wave_o` is low and `irq_o` is low. Register addresses are 0 control, 1 count, 2 first compare, 3 second compare. `bus_rdata` shows the addressed register combinationally.
- R2: While the run bit (control bit 0) is set, each source tick raises the count by one as long as the count is not equal to the active limit. With the run bit clear, the count holds.
- R3: A tick that finds the count equal to the active limit sets the count to zero. In single-limit mode the period is therefore (first compare + 1) ticks.
- R4: When the interrupt enable (control bit 5) is set, a wrapping tick gives a one-cycle `irq_o` pulse in the cycle after it. With the enable clear, no pulse occurs.
- R5: With control bit 2 set (two-limit mode), the active limit alternates first, second, first, and so on. On the internal clock, `wave_o` is high for (first + 1) cycles and low for (second + 1) cycles.
- R6: With control bit 2 clear, `wave_o` toggles on every wrap and the second compare has no effect.
- R7: With control bit 1 clear (one pass), the run bit clears itself on the final wrap and the count then stays at zero. The final wrap is the first-limit wrap in single-limit mode and the second-limit wrap in two-limit mode.
- R8: Control bits 4:3 select the source: 0 internal clock, 1 external pin rising edge, 2 `chain_tick` pulse, 3 none. An external rising edge is synchronized in two stages and advances the count at the third clock edge after the pin rises. A pin held high counts once.
- R9: A count register write loads the written value at that edge and overrides any tick in the same cycle.
- R10: Any control write restarts the phase: the first limit becomes active and the single-mode toggle clears, so in two-limit mode `wave_o` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| ev_pin | input | 1 | External event input (asynchronous) |
| chain_tick | input | 1 | One-cycle tick from a prescaler timer |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The hardest situation to reach is the cycle-exact timing of a phase boundary in two-limit mode, especially when a limit is zero and the phase flips on consecutive ticks. The bench sweeps every pair of small limits and measures the high and low run lengths of `wave_o` after the first, possibly partial, segment. One-pass termination in two-limit mode is also easy to get wrong, because the run bit must survive the first-limit wrap and clear only on the second. The bench reads the control word back at the cycles on either side of that wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMPA = 2'd2,
    REG_CMPB = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_CLK   = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_CHAIN = 2'd2,
    SRC_OFF   = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic       irq_en;
    src_sel_e   src;
    logic       dual;
    logic       cont;
    logic       run;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_n = d;
    end else begin : g_many
      assign sh_n = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         dual,
  input  logic         cont,
  input  logic         irq_en,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wd,
  input  logic         phase_clr,
  output logic [W-1:0] count,
  output logic         phase_b,
  output logic         toggle,
  output logic         done,
  output logic         irq
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         ph_q, ph_n;
  logic         tg_q, tg_n;
  logic         irq_q, irq_n;
  logic [W-1:0] limit;
  logic         wrap;

  assign limit = (dual && ph_q) ? cmp_b : cmp_a;
  assign wrap  = tick && (cnt_q == limit);

  always_comb begin
    cnt_n = cnt_q;
    ph_n  = ph_q;
    tg_n  = tg_q;
    if (tick) begin
      if (wrap) begin
        cnt_n = '0;
        ph_n  = dual ? ~ph_q : 1'b0;
        tg_n  = ~tg_q;
      end else begin
        cnt_n = cnt_q + W'(1);
      end
    end
    if (phase_clr) begin
      ph_n = 1'b0;
      tg_n = 1'b0;
    end
    if (cnt_we) cnt_n = cnt_wd;
    irq_n = wrap && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      tg_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ph_q  <= ph_n;
      tg_q  <= tg_n;
      irq_q <= irq_n;
    end
  end

  assign done    = wrap && !cont && (!dual || ph_q);
  assign count   = cnt_q;
  assign phase_b = ph_q;
  assign toggle  = tg_q;
  assign irq     = irq_q;
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         ev_pin,
  input  logic         chain_tick,
  output logic         wave_o,
  output logic         irq_o
);
  logic         rst_s_n;
  logic         ev_s, ev_d_q, ev_rise;
  ctrl_t        ctrl_q, ctrl_n;
  logic [W-1:0] cmp_a_q, cmp_b_q;
  logic         ctrl_we, cnt_we, cmpa_we, cmpb_we;
  logic         src_tick, tick;
  logic [W-1:0] cnt_q;
  logic         ph_b, tgl, done;
  logic         run_q, dual_q, cont_q, irqen_q;

  tmr_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) u_ev_sync (
    .clk(clk), .rst_n(rst_s_n), .d(ev_pin), .q(ev_s)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ev_d_q <= 1'b0;
    else          ev_d_q <= ev_s;
  end
  assign ev_rise = ev_s && !ev_d_q;

  assign ctrl_we = bus_wr && (bus_addr == REG_CTRL);
  assign cnt_we  = bus_wr && (bus_addr == REG_CNT);
  assign cmpa_we = bus_wr && (bus_addr == REG_CMPA);
  assign cmpb_we = bus_wr && (bus_addr == REG_CMPB);

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_we)   ctrl_n = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
    else if (done) ctrl_n.run = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      if (cmpa_we) cmp_a_q <= bus_wdata;
      if (cmpb_we) cmp_b_q <= bus_wdata;
    end
  end

  always_comb begin
    case (ctrl_q.src)
      SRC_CLK:   src_tick = 1'b1;
      SRC_PIN:   src_tick = ev_rise;
      SRC_CHAIN: src_tick = chain_tick;
      default:   src_tick = 1'b0;
    endcase
  end
  assign tick = ctrl_q.run && src_tick;

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_s_n), .tick(tick),
    .dual(ctrl_q.dual), .cont(ctrl_q.cont), .irq_en(ctrl_q.irq_en),
    .cmp_a(cmp_a_q), .cmp_b(cmp_b_q),
    .cnt_we(cnt_we), .cnt_wd(bus_wdata), .phase_clr(ctrl_we),
    .count(cnt_q), .phase_b(ph_b), .toggle(tgl), .done(done), .irq(irq_o)
  );

  assign run_q   = ctrl_q.run;
  assign dual_q  = ctrl_q.dual;
  assign cont_q  = ctrl_q.cont;
  assign irqen_q = ctrl_q.irq_en;

  assign wave_o = dual_q ? !ph_b : tgl;

  always_comb begin
    case (bus_addr)
      REG_CTRL: bus_rdata = W'(ctrl_q);
      REG_CNT:  bus_rdata = cnt_q;
      REG_CMPA: bus_rdata = cmp_a_q;
      default:  bus_rdata = cmp_b_q;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] cmp_b,
  input logic         dual,
  input logic         phase_b,
  input logic         cnt_we,
  input logic [W-1:0] wdata,
  input logic         cont,
  input logic         ctrl_we,
  input logic         run,
  input logic         irq,
  input logic         irq_en
);
  logic [W-1:0] act;
  assign act = (dual && phase_b) ? cmp_b : cmp_a;

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count != act) |=> count == $past(count) + W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count == act) |=> count == '0);

  p_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick && count == act && irq_en));

  p_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dual && count == act && !ctrl_we) |=> phase_b != $past(phase_b));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == act && !cont && (!dual || phase_b) && !ctrl_we) |=> !run);

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(wdata));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !phase_b);
endmodule

bind dual_cmp_timer tmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .tick(tick), .count(cnt_q),
  .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .dual(dual_q), .phase_b(ph_b),
  .cnt_we(cnt_we), .wdata(bus_wdata), .cont(cont_q), .ctrl_we(ctrl_we),
  .run(run_q), .irq(irq_o), .irq_en(irqen_q)
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 16;

  logic          clk;
  logic          rst_n;
  logic          bus_wr;
  logic [1:0]    bus_addr;
  logic [WD-1:0] bus_wdata;
  logic [WD-1:0] bus_rdata;
  logic          ev_pin;
  logic          chain_tick;
  logic          wave_o;
  logic          irq_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  dual_cmp_timer u_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pin(ev_pin),
    .chain_tick(chain_tick), .wave_o(wave_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      finish_up();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    bus_addr  = a;
    bus_wdata = WD'(d);
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int v, n, m;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    ev_pin = 1'b0; chain_tick = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 wave", int'(wave_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // R2 counting on internal clock and holding when stopped
    wr(2, 100);
    wr(0, 'h03);
    step(5);
    rd(1, v); chk("R2 count after 5 ticks", v, 5);
    wr(0, 'h02);
    rd(1, v); chk("R2 tick at stop edge", v, 6);
    step(4);
    rd(1, v); chk("R2 hold while stopped", v, 6);

    // R9 count write overrides tick
    wr(0, 'h03);
    wr(1, 40);
    rd(1, v); chk("R9 load overrides tick", v, 40);
    step(3);
    rd(1, v); chk("R9 count after load", v, 43);

    // R3 R4 R6 single mode with interrupt, second compare ignored
    wr(0, 0); wr(1, 0); wr(2, 3); wr(3, 1);
    wr(0, 'h23);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      rd(1, v);
      chk("R3 wrap sequence", v, k % 4);
      chk("R4 irq pulse", int'(irq_o), (k % 4 == 0) ? 1 : 0);
      chk("R6 single toggle", int'(wave_o), (k / 4) % 2);
    end
    wr(0, 0); wr(1, 0);
    wr(0, 'h03);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R4 no irq when disabled", int'(irq_o), 0);
    end

    // R5 two-limit sweep over small limits
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr(0, 0); wr(2, a); wr(3, b); wr(1, 0);
        wr(0, 'h07);
        chk("R5 starts high", int'(wave_o), 1);
        n = 0; m = 0;
        while (wave_o == 1'b1 && n < 50) begin n++; @(negedge clk); end
        n = 0;
        while (wave_o == 1'b0 && n < 50) begin n++; @(negedge clk); end
        while (wave_o == 1'b1 && m < 50) begin m++; @(negedge clk); end
        chk($sformatf("R5 low len a=%0d b=%0d", a, b), n, b + 1);
        chk($sformatf("R5 high len a=%0d b=%0d", a, b), m, a + 1);
      end
    end

    // R10 control write restarts the first phase
    wr(0, 0); wr(2, 3); wr(3, 3); wr(1, 0);
    wr(0, 'h07);
    n = 0;
    while (wave_o == 1'b1 && n < 50) begin n++; @(negedge clk); end
    chk("R10 in second phase", int'(wave_o), 0);
    wr(0, 'h07);
    chk("R10 wave high after ctrl write", int'(wave_o), 1);

    // R7 one pass, single mode
    wr(0, 0); wr(1, 0); wr(2, 2);
    wr(0, 'h01);
    step(2);
    rd(0, v); chk("R7 single still running", v & 1, 1);
    step(1);
    rd(0, v); chk("R7 single run cleared", v & 1, 0);
    step(4);
    rd(1, v); chk("R7 single count stays zero", v, 0);

    // R7 one pass, two-limit mode
    wr(0, 0); wr(1, 0); wr(2, 1); wr(3, 2);
    wr(0, 'h05);
    step(2);
    rd(0, v); chk("R7 dual runs past first wrap", v & 1, 1);
    step(2);
    rd(0, v); chk("R7 dual still running", v & 1, 1);
    step(1);
    rd(0, v); chk("R7 dual run cleared", v & 1, 0);
    step(3);
    rd(1, v); chk("R7 dual count stays zero", v, 0);

    // R8 external pin source
    wr(0, 0); wr(1, 0); wr(2, 100);
    wr(0, 'h0B);
    ev_pin = 1'b1;
    step(2);
    rd(1, v); chk("R8 pin not yet counted", v, 0);
    step(1);
    rd(1, v); chk("R8 pin counted at third edge", v, 1);
    step(5);
    rd(1, v); chk("R8 held pin counts once", v, 1);
    ev_pin = 1'b0; step(4);
    ev_pin = 1'b1; step(4);
    rd(1, v); chk("R8 second pin edge", v, 2);
    ev_pin = 1'b0;

    // R8 chain tick source
    wr(0, 0); wr(1, 0);
    wr(0, 'h13);
    for (int p = 0; p < 3; p++) begin
      chain_tick = 1'b1; step(1);
      chain_tick = 1'b0; step(2);
    end
    rd(1, v); chk("R8 chain pulses counted", v, 3);

    // R8 source off
    wr(0, 'h1B);
    step(10);
    rd(1, v); chk("R8 no source holds count", v, 3);

    finish_up();
  end
endmodule